// File: doc/BRIEF.md
# I2C Bit-Rate Clock Generator

This block derives the serial-clock timing for an I2C master from a fast reference clock. The divide chain has two stages. The first is a power-of-two predivider. The second is an 8-bit programmable half-period counter whose length is the divider value plus a fixed offset of three, plus two more when the filter flag is set. At the end of each half-period the block emits a one-cycle tick and toggles an SCL phase signal. The phase signal therefore runs at the reference rate divided by `P * 2 * (div + 3 + 2*filt)`, and the tick runs at twice that rate.

Software programs the block through two write-strobed registers. The mode register holds the enable, the predivider select and the filter flag. The divider register holds the 8-bit count. The working copy of the settings is reloaded only at a half-period boundary, so no half-period is ever cut short or stretched by a mid-period write. While the block is disabled, every counter is held at zero.

Top module: `i2c_bitclk_gen`

## Requirements
- R1: After reset, `tick_o` and `scl_o` are 0 and the block is disabled.
- R2: While disabled, no tick is produced and `scl_o` stays 0. A later enable starts a full half-period from zero.
- R3: The predivider ratio is P = 2^(5 - sel), where sel is `mode_i[2:1]`. This gives ratios of 32, 16, 8 and 4 for sel = 0 to 3.
- R4: Setting the filter flag, `mode_i[3]`, lengthens each half-period by 2·P reference cycles.
- R5: The divider accepts the full range 0 to 255. One half-period lasts T = P·(div + 3 + 2·filt) reference cycles, from a minimum of 12 to a maximum of 8320.
- R6: `tick_o` is high for exactly one cycle per half-period. `scl_o` changes exactly in the cycles where `tick_o` is high, and it starts at 0 after enable.
- R7: A divider or mode write made while the block runs does not change the half-period in progress. The new T applies from the half-period that follows the next tick.
- R8: Mode register encoding: bit 0 is the enable, bits 2:1 are sel and bit 3 is the filter flag. Writing bit 0 as 0 stops ticking whatever the other bits hold.
- R9: The first tick appears T cycles after the clock edge that samples the enabling mode write. Later ticks follow every T cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_we_i | input | 1 | Write strobe for the mode register |
| mode_i | input | 4 | Mode data: bit 0 enable, bits 2:1 predivider select, bit 3 filter |
| div_we_i | input | 1 | Write strobe for the divider register |
| div_i | input | 8 | Divider value, 0 to 255 |
| tick_o | output | 1 | One-cycle pulse at each half-period end |
| scl_o | output | 1 | SCL phase, toggled on every tick |

## Verification
Take the clock edge that samples an enabling mode write as cycle 0. The first tick and the first SCL toggle are due in cycle T, and each later one is due T cycles after the previous one. The bench counts reference cycles from that edge and samples the outputs at the falling edge of every cycle. It expects `tick_o` high only in cycles that are multiples of the current T, and `scl_o` equal to the parity of the tick count. For a write made mid-run, the old T still covers the tick already pending, and the next gap uses the new T. After a disabling write, the outputs are checked from the second cycle onwards. The first cycle after that write still finishes on the old enable.

// File: rtl/i2c_bitclk_pkg.sv
`timescale 1ns/1ps
package i2c_bitclk_pkg;
  localparam int unsigned DIV_W     = 8;
  localparam int unsigned SEL_W     = 2;
  localparam int unsigned PRE_W     = 5;   // log2 of the largest predivide ratio
  localparam int unsigned MODE_W    = SEL_W + 2;
  localparam int unsigned HALF_W    = DIV_W + 1;
  localparam int unsigned FIXED_ADD = 3;

  // mode register fields
  localparam int unsigned MODE_EN   = 0;
  localparam int unsigned MODE_SEL  = 1;
  localparam int unsigned MODE_FILT = SEL_W + 1;

  typedef struct packed {
    logic             filt;
    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] div;
  } rate_cfg_t;
endpackage

// File: rtl/i2c_bitclk_cfg.sv
`timescale 1ns/1ps
module i2c_bitclk_cfg
  import i2c_bitclk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              div_we_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              half_done_i,
  output logic              en_o,
  output rate_cfg_t         act_o
);
  logic      en_q, en_d;
  rate_cfg_t prog_q, prog_d, act_q;

  always_comb begin
    en_d   = en_q;
    prog_d = prog_q;
    if (mode_we_i) begin
      en_d        = mode_i[MODE_EN];
      prog_d.sel  = mode_i[MODE_SEL +: SEL_W];
      prog_d.filt = mode_i[MODE_FILT];
    end
    if (div_we_i) prog_d.div = div_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      prog_q <= '0;
      act_q  <= '0;
    end else begin
      en_q   <= en_d;
      prog_q <= prog_d;
      // working copy follows while idle, otherwise only at a half-period end
      if (!en_q || half_done_i) act_q <= prog_d;
    end
  end

  assign en_o  = en_q;
  assign act_o = act_q;
endmodule

// File: rtl/i2c_bitclk_prediv.sv
`timescale 1ns/1ps
module i2c_bitclk_prediv
  import i2c_bitclk_pkg::*;
#(
  parameter int unsigned SW = SEL_W,
  parameter int unsigned PW = PRE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [SW-1:0] sel_i,
  output logic          wrap_o,
  output logic [PW-1:0] cnt_o,
  output logic [PW-1:0] last_o
);
  localparam int unsigned NSEL = 2 ** SW;

  logic [PW-1:0] last_tab [NSEL];
  logic [PW-1:0] cnt_q;

  // terminal count per select: 2^(PW-g) - 1
  for (genvar g = 0; g < NSEL; g++) begin : g_last
    assign last_tab[g] = PW'((32'd1 << (PW - g)) - 32'd1);
  end

  assign last_o = last_tab[sel_i];
  assign wrap_o = en_i && (cnt_q == last_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (wrap_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/i2c_bitclk_halfdiv.sv
`timescale 1ns/1ps
module i2c_bitclk_halfdiv
  import i2c_bitclk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              step_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              filt_i,
  output logic              done_o,
  output logic              tick_o,
  output logic              scl_o,
  output logic [HALF_W-1:0] cnt_o,
  output logic [HALF_W-1:0] len_o
);
  logic [HALF_W-1:0] cnt_q;
  logic              tick_q, scl_q;

  assign len_o  = {1'b0, div_i} + HALF_W'(FIXED_ADD) + (filt_i ? HALF_W'(2) : '0);
  assign done_o = step_i && (cnt_q == len_o - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
      scl_q  <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
      scl_q  <= 1'b0;
    end else begin
      tick_q <= done_o;
      if (done_o) begin
        cnt_q <= '0;
        scl_q <= ~scl_q;
      end else if (step_i) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign tick_o = tick_q;
  assign scl_o  = scl_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/i2c_bitclk_gen.sv
`timescale 1ns/1ps
module i2c_bitclk_gen
  import i2c_bitclk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              div_we_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic              tick_o,
  output logic              scl_o
);
  logic              en_w, pre_wrap_w, half_done_w;
  rate_cfg_t         act_w;
  logic [PRE_W-1:0]  pre_cnt_w, pre_last_w;
  logic [HALF_W-1:0] half_cnt_w, half_len_w;

  i2c_bitclk_cfg u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_we_i   (mode_we_i),
    .mode_i      (mode_i),
    .div_we_i    (div_we_i),
    .div_i       (div_i),
    .half_done_i (half_done_w),
    .en_o        (en_w),
    .act_o       (act_w)
  );

  i2c_bitclk_prediv u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_w),
    .sel_i  (act_w.sel),
    .wrap_o (pre_wrap_w),
    .cnt_o  (pre_cnt_w),
    .last_o (pre_last_w)
  );

  i2c_bitclk_halfdiv u_half (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_w),
    .step_i (pre_wrap_w),
    .div_i  (act_w.div),
    .filt_i (act_w.filt),
    .done_o (half_done_w),
    .tick_o (tick_o),
    .scl_o  (scl_o),
    .cnt_o  (half_cnt_w),
    .len_o  (half_len_w)
  );
endmodule

// File: rtl/i2c_bitclk_chk.sv
`timescale 1ns/1ps
module i2c_bitclk_chk
  import i2c_bitclk_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_o,
  input logic              scl_o,
  input logic              en_i,
  input rate_cfg_t         act_i,
  input logic [PRE_W-1:0]  pre_cnt_i,
  input logic [PRE_W-1:0]  pre_last_i,
  input logic [HALF_W-1:0] half_cnt_i,
  input logic [HALF_W-1:0] half_len_i
);
  p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !tick_o && !scl_o);

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> !tick_o && !scl_o);

  p_pre_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_cnt_i <= pre_last_i);

  p_half_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_cnt_i < half_len_i);

  p_tick_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  p_scl_toggle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> scl_o != $past(scl_o));

  p_scl_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o && $past(en_i) |-> $stable(scl_o));

  p_cfg_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o && $past(en_i) |-> $stable(act_i));
endmodule

bind i2c_bitclk_gen i2c_bitclk_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_o     (tick_o),
  .scl_o      (scl_o),
  .en_i       (en_w),
  .act_i      (act_w),
  .pre_cnt_i  (pre_cnt_w),
  .pre_last_i (pre_last_w),
  .half_cnt_i (half_cnt_w),
  .half_len_i (half_len_w)
);

// File: tb/i2c_bitclk_gen_tb_top.sv
`timescale 1ns/1ps
module i2c_bitclk_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_we = 1'b0;
  logic [3:0] mode = '0;
  logic       div_we = 1'b0;
  logic [7:0] div = '0;
  logic       tick, scl;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  i2c_bitclk_gen dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .mode_we_i (mode_we),
    .mode_i    (mode),
    .div_we_i  (div_we),
    .div_i     (div),
    .tick_o    (tick),
    .scl_o     (scl)
  );

  // half-period in reference cycles, from R3/R4/R5
  function automatic int half_len(input int sel, input int dv, input bit f);
    return (2 ** (5 - sel)) * (dv + 3 + (f ? 2 : 0));
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic stop_blk();
    mode = 4'b0000; mode_we = 1'b1;
    @(negedge clk); mode_we = 1'b0;
    @(negedge clk);
  endtask

  // enable with (sel,dv,f), watch ncyc cycles; optional divider rewrite at chg_at
  task automatic run_seg(input int sel, input int dv, input bit f, input int ncyc,
                         input int chg_at, input int dv2, input string req);
    int t1, t2, next, ticks;
    bit first;
    t1 = half_len(sel, dv, f);
    t2 = (chg_at > 0) ? half_len(sel, dv2, f) : t1;
    div = 8'(dv); div_we = 1'b1;
    @(negedge clk); div_we = 1'b0;
    mode = {f, 2'(sel), 1'b1}; mode_we = 1'b1;   // R8 encoding
    @(negedge clk); mode_we = 1'b0;               // cycle 0
    chk("R2", tick, 1'b0);
    next = t1; ticks = 0; first = 1'b1;
    for (int c = 1; c <= ncyc; c++) begin
      @(negedge clk);
      div_we = 1'b0;
      if (c == next) begin
        ticks++;
        chk(first ? "R9" : req, tick, 1'b1);
        first = 1'b0;
        next += t2;
      end else begin
        chk(req, tick, 1'b0);
      end
      chk("R6", scl, ticks[0]);
      if (chg_at > 0 && c == chg_at) begin
        div = 8'(dv2); div_we = 1'b1;             // R7: mid-period rewrite
      end
    end
    stop_blk();
  endtask

  task automatic quiet_chk(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      chk("R2", tick, 1'b0);
      chk("R2", scl, 1'b0);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1c2b));
    repeat (3) @(negedge clk);
    chk("R1", tick, 1'b0);
    chk("R1", scl, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", tick, 1'b0);
    chk("R1", scl, 1'b0);
    quiet_chk(20);

    run_seg(3, 0,   1'b0, 40,   0, 0, "R5");   // T = 12
    run_seg(3, 255, 1'b0, 2100, 0, 0, "R5");   // T = 1032
    run_seg(0, 0,   1'b1, 400,  0, 0, "R4");   // T = 160
    run_seg(0, 0,   1'b0, 300,  0, 0, "R4");   // T = 96
    run_seg(1, 10,  1'b0, 650,  0, 0, "R3");   // T = 208
    run_seg(2, 10,  1'b1, 500,  0, 0, "R3");   // T = 120
    run_seg(2, 20,  1'b0, 400, 50, 5,  "R7");  // 184 then 64
    run_seg(3, 2,   1'b0, 300, 7,  40, "R7");  // 20 then 172

    // R8: enable bit clear with other fields set keeps it idle
    div = 8'd0; div_we = 1'b1;
    mode = 4'b1110; mode_we = 1'b1;
    @(negedge clk); div_we = 1'b0; mode_we = 1'b0;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      chk("R8", tick, 1'b0);
    end

    // R2: stop mid-run, stay silent, restart from zero
    div = 8'd1; div_we = 1'b1;
    @(negedge clk); div_we = 1'b0;
    mode = 4'b0111; mode_we = 1'b1;
    @(negedge clk); mode_we = 1'b0;
    repeat (30) @(negedge clk);
    mode = 4'b0110; mode_we = 1'b1;
    @(negedge clk); mode_we = 1'b0;
    quiet_chk(50);
    run_seg(3, 1, 1'b0, 80, 0, 0, "R2");

    for (int k = 0; k < 10; k++) begin
      int s, d;
      bit f;
      s = int'($urandom % 4);
      d = int'($urandom % 64);
      f = 1'($urandom % 2);
      run_seg(s, d, f, 3 * half_len(s, d, f) + 5, 0, 0, "R3");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule